// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block takes level requests from up to eight devices and one non-maskable source, and picks the most urgent one. It then runs a three-party exchange. First it raises a single request line toward the processor. When the processor pulses its acknowledge, the block passes the acknowledge to the chosen device and waits for that device to return a vector. The vector is presented to the processor after a two-cycle branch delay. If no vector arrives within a fixed window, a bus error is raised instead.

The block keeps a current priority level so that interrupts can nest. A new request is raised only when its level is strictly above the level now in service. Each accepted source leaves a bit in an interrupt-latch register when it is acknowledged, and a bit in a nesting-mask register when its vector is taken. An end-of-interrupt pulse clears the highest nesting bit and the matching latch bit, which drops the current level back to the one that was interrupted. Handler code, register save and restore, and the processor itself are outside the block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: An asserted `irq_in`/`nmi_in` passes one synchroniser stage and one recognition stage, so `cpu_int_req` rises after the second rising edge following the request, and only while the controller is idle.
- R2: Priority is fixed: the non-maskable source outranks source 7, which outranks source 6, and so on down to source 0. After `cpu_ack`, `dev_ack` is one-hot on the selected source, with bit N_SRC standing for the non-maskable source.
- R3: A request whose level is not above `cur_lvl` is not raised. It is raised one cycle after a return lowers `cur_lvl` beneath it. A higher-level request raised during service nests on top.
- R4: With `glob_en` low, or with `src_mask[i]` set to 1, source i is never raised. Neither input affects `nmi_in`.
- R5: The `latch_q` bit of the selected source is set on the edge that accepts `cpu_ack`.
- R6: A `dev_vec_valid` seen while `dev_ack` is high captures `dev_vec`. On that edge the source's `nest_q` bit is set. Two edges later, `vec_valid` pulses for one cycle with `vec_out` equal to the captured vector.
- R7: If no vector arrives, `bus_err` pulses for one cycle on the 16th edge after the acknowledge edge (TMO_CYC = 16). On that same edge `dev_ack` drops and the source's latch bit clears, while `nest_q` stays unchanged.
- R8: A `cpu_ret` pulse clears the highest set `nest_q` bit and the same `latch_q` bit, which restores the previous level.
- R9: A `cpu_ret` while `nest_q` is zero changes no register and pulses `ret_err` for one cycle.
- R10: `cur_lvl` is 0 when nothing is in service. It is i+1 when source i is the highest nesting bit, and N_SRC+1 when that bit is the non-maskable one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Device request levels |
| nmi_in | input | 1 | Non-maskable request level |
| glob_en | input | 1 | Global enable for the maskable sources |
| src_mask | input | N_SRC | Per-source block, 1 = blocked |
| cpu_int_req | output | 1 | Interrupt request toward the processor |
| cpu_ack | input | 1 | Processor acknowledge pulse |
| dev_ack | output | N_SRC+1 | One-hot acknowledge to the selected device |
| dev_vec_valid | input | 1 | Device vector strobe |
| dev_vec | input | VEC_W | Device vector |
| vec_valid | output | 1 | Vector ready for the handler table lookup |
| vec_out | output | VEC_W | Vector presented to the processor |
| bus_err | output | 1 | Vector timeout pulse |
| cpu_ret | input | 1 | End-of-interrupt pulse |
| ret_err | output | 1 | Return with nothing in service |
| cur_lvl | output | clog2(N_SRC+2) | Current priority level |
| latch_q | output | N_SRC+1 | Interrupt-latch register |
| nest_q | output | N_SRC+1 | Nesting-mask register |

## Verification
The bench builds the block with its defaults: N_SRC = 8, VEC_W = 8 and TMO_CYC = 16. At these values the non-maskable bit sits at index 8, and the full 16-cycle vector window is short enough to count out edge by edge. The top maskable source and the non-maskable source are both reachable, so the scenarios can stack two nested levels, return through them one at a time, and watch a blocked low-priority request come out once the level falls below it.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAITV,
    ST_BR1,
    ST_BR2
  } pic_state_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/pic_enc.sv
// Highest set bit, returned as a level: 0 = none, bit i -> i+1
module pic_enc #(
  parameter int W  = 9,
  parameter int LW = 4
) (
  input  logic [W-1:0]  v,
  output logic [LW-1:0] lvl
);
  function automatic logic [LW-1:0] hi_lvl(input logic [W-1:0] x);
    logic [LW-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++)
      if (x[i]) r = LW'(i + 1);
    return r;
  endfunction

  assign lvl = hi_lvl(v);
endmodule

// File: rtl/pic_nest.sv
module pic_nest #(
  parameter int NL = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] sel_oh,
  input  logic [NL-1:0] cur_oh,
  input  logic          lat_set,
  input  logic          lat_clr,
  input  logic          commit,
  input  logic          ret,
  output logic [NL-1:0] latch_q,
  output logic [NL-1:0] nest_q,
  output logic          ret_err
);
  logic [NL-1:0] ret_clr;
  assign ret_clr = ret ? cur_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      nest_q  <= '0;
      ret_err <= 1'b0;
    end else begin
      latch_q <= (latch_q | (lat_set ? sel_oh : '0))
                 & ~(lat_clr ? sel_oh : '0) & ~ret_clr;
      nest_q  <= (nest_q | (commit ? sel_oh : '0)) & ~ret_clr;
      ret_err <= ret && (nest_q == '0);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_SRC   = 8,
  parameter int VEC_W   = 8,
  parameter int TMO_CYC = 16,
  localparam int NL     = N_SRC + 1,
  localparam int LVL_W  = $clog2(N_SRC + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             nmi_in,
  input  logic             glob_en,
  input  logic [N_SRC-1:0] src_mask,
  output logic             cpu_int_req,
  input  logic             cpu_ack,
  output logic [NL-1:0]    dev_ack,
  input  logic             dev_vec_valid,
  input  logic [VEC_W-1:0] dev_vec,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_out,
  output logic             bus_err,
  input  logic             cpu_ret,
  output logic             ret_err,
  output logic [LVL_W-1:0] cur_lvl,
  output logic [NL-1:0]    latch_q,
  output logic [NL-1:0]    nest_q
);
  import pic_pkg::*;

  localparam int TMO_W = $clog2(TMO_CYC + 1);

  function automatic logic [NL-1:0] lvl_oh(input logic [LVL_W-1:0] l);
    logic [NL-1:0] r;
    for (int i = 0; i < NL; i++) r[i] = (l == LVL_W'(i + 1));
    return r;
  endfunction

  pic_state_e       state;
  logic [NL-1:0]    req_s, pend;
  logic [LVL_W-1:0] win_lvl, sel_lvl;
  logic [NL-1:0]    sel_oh, cur_oh;
  logic [TMO_W-1:0] tmo_cnt;
  logic [VEC_W-1:0] vec_q;
  logic             bus_err_q;
  logic             win_fire, lat_set, commit_evt, berr_evt;

  pic_sync #(.W(NL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({nmi_in, irq_in}), .q(req_s)
  );

  assign pend = {req_s[N_SRC], req_s[N_SRC-1:0] & ~src_mask & {N_SRC{glob_en}}};

  pic_enc #(.W(NL), .LW(LVL_W)) u_pend_enc (.v(pend),   .lvl(win_lvl));
  pic_enc #(.W(NL), .LW(LVL_W)) u_cur_enc  (.v(nest_q), .lvl(cur_lvl));

  assign win_fire   = win_lvl > cur_lvl;
  assign sel_oh     = lvl_oh(sel_lvl);
  assign cur_oh     = lvl_oh(cur_lvl);
  assign lat_set    = (state == ST_REQ) && cpu_ack;
  assign commit_evt = (state == ST_WAITV) && dev_vec_valid;
  assign berr_evt   = (state == ST_WAITV) && !dev_vec_valid
                      && (tmo_cnt == TMO_W'(TMO_CYC - 1));

  pic_nest #(.NL(NL)) u_nest (
    .clk(clk), .rst_n(rst_n), .sel_oh(sel_oh), .cur_oh(cur_oh),
    .lat_set(lat_set), .lat_clr(berr_evt), .commit(commit_evt),
    .ret(cpu_ret), .latch_q(latch_q), .nest_q(nest_q), .ret_err(ret_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sel_lvl   <= '0;
      tmo_cnt   <= '0;
      vec_q     <= '0;
      bus_err_q <= 1'b0;
    end else begin
      bus_err_q <= berr_evt;
      unique case (state)
        ST_IDLE: if (win_fire) begin
          sel_lvl <= win_lvl;
          state   <= ST_REQ;
        end
        ST_REQ: if (cpu_ack) begin
          tmo_cnt <= '0;
          state   <= ST_WAITV;
        end
        ST_WAITV: begin
          if (dev_vec_valid) begin
            vec_q <= dev_vec;
            state <= ST_BR1;
          end else if (berr_evt) begin
            state <= ST_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        ST_BR1:  state <= ST_BR2;
        ST_BR2:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cpu_int_req = (state == ST_REQ);
  assign dev_ack     = (state == ST_WAITV) ? sel_oh : '0;
  assign vec_valid   = (state == ST_BR2);
  assign vec_out     = vec_q;
  assign bus_err     = bus_err_q;
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int NL    = 9,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_int_req,
  input logic [NL-1:0]    dev_ack,
  input logic             dev_vec_valid,
  input logic             vec_valid,
  input logic             bus_err,
  input logic             cpu_ret,
  input logic             ret_err,
  input logic [NL-1:0]    nest_q,
  input logic [LVL_W-1:0] sel_lvl,
  input logic [LVL_W-1:0] cur_lvl,
  input logic             commit_evt
);
  // R2
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack));

  // R3
  req_outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int_req |-> (sel_lvl > cur_lvl));

  // R6
  vec_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(dev_vec_valid, 2));

  // R6
  nest_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && !cpu_ret) |=> ($countones(nest_q) == $past($countones(nest_q)) + 1));

  // R7
  berr_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ($past(|dev_ack) && !vec_valid && (dev_ack == '0)));

  // R8
  nest_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ret && (nest_q != '0) && !commit_evt)
      |=> ($countones(nest_q) == $past($countones(nest_q)) - 1));

  // R9
  empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ret && (nest_q == '0) && !commit_evt) |=> (ret_err && (nest_q == '0)));
endmodule

bind prio_irq_ctrl pic_chk #(.NL(NL), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_int_req(cpu_int_req), .dev_ack(dev_ack),
  .dev_vec_valid(dev_vec_valid), .vec_valid(vec_valid), .bus_err(bus_err),
  .cpu_ret(cpu_ret), .ret_err(ret_err), .nest_q(nest_q), .sel_lvl(sel_lvl),
  .cur_lvl(cur_lvl), .commit_evt(commit_evt)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam int N = 8;

  logic       clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0, src_mask = '0;
  logic       nmi_in = 0, glob_en = 1, cpu_ack = 0, dev_vec_valid = 0, cpu_ret = 0;
  logic [7:0] dev_vec = '0;
  logic       cpu_int_req, vec_valid, bus_err, ret_err;
  logic [N:0] dev_ack, latch_q, nest_q;
  logic [7:0] vec_out;
  logic [3:0] cur_lvl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in), .glob_en(glob_en),
    .src_mask(src_mask), .cpu_int_req(cpu_int_req), .cpu_ack(cpu_ack),
    .dev_ack(dev_ack), .dev_vec_valid(dev_vec_valid), .dev_vec(dev_vec),
    .vec_valid(vec_valid), .vec_out(vec_out), .bus_err(bus_err), .cpu_ret(cpu_ret),
    .ret_err(ret_err), .cur_lvl(cur_lvl), .latch_q(latch_q), .nest_q(nest_q)
  );

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic do_ack();
    cpu_ack = 1; step(); cpu_ack = 0;
  endtask

  task automatic do_vec(int v);
    dev_vec = 8'(v); dev_vec_valid = 1; step(); dev_vec_valid = 0; step();
  endtask

  task automatic do_ret();
    cpu_ret = 1; step(); cpu_ret = 0;
  endtask

  task automatic t_reset();
    check("R1 reset req", cpu_int_req, 0);
    check("R10 reset level", cur_lvl, 0);
    check("R5 reset latch", latch_q, 0);
    check("R8 reset nest", nest_q, 0);
  endtask

  task automatic t_basic();
    irq_in[3] = 1; step();
    check("R1 not yet raised", cpu_int_req, 0);
    step();
    check("R1 raised after two edges", cpu_int_req, 1);
    do_ack();
    check("R2 ack to source 3", dev_ack, 'h8);
    check("R5 latch on ack", latch_q, 'h8);
    check("R6 nest not yet set", nest_q, 0);
    step(2);
    do_vec('h5A);
    check("R6 vec_valid", vec_valid, 1);
    check("R6 vec_out", vec_out, 'h5A);
    check("R6 nest bit", nest_q, 'h8);
    check("R10 level of source 3", cur_lvl, 4);
    irq_in[3] = 0; step();
    check("R6 single-cycle vec_valid", vec_valid, 0);
    do_ret();
    check("R8 nest cleared", nest_q, 0);
    check("R8 latch cleared", latch_q, 0);
    check("R10 level back to 0", cur_lvl, 0);
    step(3);
    check("R1 no request after return", cpu_int_req, 0);
  endtask

  task automatic t_prio_nest();
    irq_in = 8'h44; step(2);
    check("R2 request raised", cpu_int_req, 1);
    do_ack();
    check("R2 higher source 6 wins", dev_ack, 'h40);
    do_vec('h66);
    check("R10 level of source 6", cur_lvl, 7);
    irq_in[6] = 0; step(4);
    check("R3 lower source 2 blocked", cpu_int_req, 0);
    irq_in[7] = 1; step(2);
    check("R3 higher source 7 nests", cpu_int_req, 1);
    do_ack();
    check("R2 ack to source 7", dev_ack, 'h80);
    do_vec('h77);
    check("R3 two nest bits", nest_q, 'hC0);
    check("R10 level of source 7", cur_lvl, 8);
    irq_in[7] = 0; step();
    do_ret();
    check("R8 previous level restored", cur_lvl, 7);
    check("R8 only top bit cleared", nest_q, 'h40);
    check("R8 latch top bit cleared", latch_q, 'h40);
    step(3);
    check("R3 source 2 still blocked", cpu_int_req, 0);
    do_ret();
    check("R8 level 0", cur_lvl, 0);
    step();
    check("R3 source 2 raised after return", cpu_int_req, 1);
    do_ack();
    check("R2 ack to source 2", dev_ack, 'h4);
    do_vec('h22);
    check("R10 level of source 2", cur_lvl, 3);
    irq_in[2] = 0; step();
    do_ret();
  endtask

  task automatic t_gate();
    src_mask = 8'h10; irq_in[4] = 1; step(4);
    check("R4 mask bit blocks", cpu_int_req, 0);
    src_mask = '0; glob_en = 0; step(4);
    check("R4 global enable blocks", cpu_int_req, 0);
    nmi_in = 1; step(2);
    check("R4 nmi ignores enable", cpu_int_req, 1);
    do_ack();
    check("R2 ack to nmi bit", dev_ack, 'h100);
    do_vec('h99);
    check("R10 nmi level", cur_lvl, 9);
    nmi_in = 0; irq_in[4] = 0; step();
    do_ret();
    check("R8 level 0 after nmi", cur_lvl, 0);
    glob_en = 1; step(3);
  endtask

  task automatic t_tmo();
    irq_in[5] = 1; step(2);
    do_ack();
    irq_in[5] = 0;
    check("R5 latch source 5", latch_q, 'h20);
    step(15);
    check("R7 no bus error yet", bus_err, 0);
    check("R7 ack held in window", dev_ack, 'h20);
    step();
    check("R7 bus error on 16th edge", bus_err, 1);
    check("R7 ack dropped", dev_ack, 0);
    check("R7 latch cleared", latch_q, 0);
    check("R7 nest untouched", nest_q, 0);
    step();
    check("R7 single-cycle bus error", bus_err, 0);
    check("R7 no handler vector", vec_valid, 0);
  endtask

  task automatic t_empty_ret();
    do_ret();
    check("R9 ret_err pulse", ret_err, 1);
    check("R9 nest unchanged", nest_q, 0);
    check("R9 latch unchanged", latch_q, 0);
    step();
    check("R9 ret_err single cycle", ret_err, 0);
  endtask

  initial begin
    step(3); rst_n = 1; step();
    t_reset();
    t_basic();
    t_prio_nest();
    t_gate();
    t_tmo();
    t_empty_ret();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule